// File: doc/BRIEF.md
# SDRAM Refresh-Aware Clock Switch Sequencer

This block moves the memory bus to a new clock frequency without leaving the SDRAM refresh interval invalid at any point. A request carries the new memory bus frequency in kHz, a flag saying whether the SDRAM clock is divided by two, and the new clock configuration word. When the request is taken, the block samples the current refresh register and the memory bank configuration word. From the bank configuration it derives the SDRAM row count. An iterative divider then computes the refresh interval count for the new frequency.

The change runs as a fixed sequence. First comes a preset write to the refresh register, which applies any change that makes refresh safer at the lower speed. Next a frequency-change strobe is written into the clock configuration and held for a set number of cycles. The sequencer then waits for the clock to report that it has relocked. Last comes a postset write that applies the final interval and clears the divide-by-two bits if needed. A one-cycle done pulse closes the sequence. A request that arrives while the sequence is running is refused.

Top module: `clksw_refresh_seq`

## Requirements
- R1: The row count is 2^(11+m), where m is the larger of two 2-bit fields of `mem_cfg`. The low field is bits 6:5 and counts only if bit 0 or bit 1 is set. The high field is bits 22:21 and counts only if bit 16 or bit 17 is set. A field that does not count is taken as 0.
- R2: With the default formula selection, the new interval is floor(floor(freq_khz*64/(rows-31))/32). A value above 0xFFF saturates to 0xFFF. The other formula selection uses floor(freq_khz*64/(rows*32)).
- R3: The preset write carries the new interval in bits 11:0 only when the interval in `cur_refresh` is strictly larger. Otherwise it keeps the current interval.
- R4: The postset write always carries the new interval in bits 11:0. Every bit of `cur_refresh` other than the interval and the divide-by-two bits passes through unchanged in both writes.
- R5: The divide-by-two bits are bits 17 and 19. When `req_div2` is 1, both bits are set in both writes. When it is 0, the preset leaves them as they were and the postset clears them.
- R6: The order is fixed: one preset write, then the clock configuration strobe, then one postset write. No refresh write takes place while the strobe is active.
- R7: `clkcfg_wr_data` equals the requested word with bit 1 (change start) forced to 1. Bit 0 (turbo), bit 2 (half-turbo) and bit 3 (fast bus) pass through. `clkcfg_wr_en` is held for exactly STROBE_CYC cycles (default 4).
- R8: The postset write takes place only in the cycle after `relock_ack` has been sampled high, once the strobe has ended.
- R9: `done` is high for exactly one cycle, the cycle after the postset write. `req_busy` is high from the cycle after a request is taken through the `done` cycle. A request made while busy is ignored and never starts a second sequence.
- R10: While in reset, and after reset until a request arrives, `req_busy`, `done`, `ref_wr_en` and `clkcfg_wr_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Start a frequency change (taken only when not busy) |
| req_freq_khz | input | FREQ_W | New memory bus frequency in kHz |
| req_div2 | input | 1 | New setting divides the SDRAM clock by two |
| req_clkcfg | input | CFG_W | New clock configuration word |
| mem_cfg | input | REG_W | Memory bank configuration word |
| cur_refresh | input | REG_W | Current refresh register contents |
| relock_ack | input | 1 | Clock has relocked after the change |
| req_busy | output | 1 | Sequence in progress; requests refused |
| ref_wr_en | output | 1 | Refresh register write strobe |
| ref_wr_data | output | REG_W | Refresh register write value |
| clkcfg_wr_en | output | 1 | Clock configuration write, held for the strobe length |
| clkcfg_wr_data | output | CFG_W | Clock configuration value with change-start set |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `mem_cfg` and `cur_refresh` are valid in the cycle a request is taken. They also assume that `relock_ack` reports a relock of the clock only after the strobe. The divider identity and the interval bound rest on that sampled data. The bench drives every request input at the falling edge for one cycle only. It raises `relock_ack` only after it has seen the strobe end, and drops it again before the next request. It keeps frequencies below 2^24, so the product with 64 fits the dividend.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CALC,
    ST_PRE,
    ST_STRB,
    ST_WACK,
    ST_POST,
    ST_DONE
  } seq_state_t;

  // bit of the clock configuration word that starts the frequency change
  localparam int FCS_BIT = 1;

endpackage

// File: rtl/clksw_rowcount.sv
module clksw_rowcount #(
  parameter int CFG_W = 32,
  parameter int ROW_W = 15
) (
  input  logic [CFG_W-1:0] mem_cfg,
  output logic [ROW_W-1:0] rows
);

  logic [1:0] lo_fld, hi_fld, big_fld;
  logic       cfg_unused;

  assign cfg_unused = ^mem_cfg;

  always_comb begin
    lo_fld  = (mem_cfg[0]  | mem_cfg[1])  ? mem_cfg[6:5]   : 2'd0;
    hi_fld  = (mem_cfg[16] | mem_cfg[17]) ? mem_cfg[22:21] : 2'd0;
    big_fld = (lo_fld > hi_fld) ? lo_fld : hi_fld;
    rows    = ROW_W'(1) << (5'd11 + {3'b000, big_fld});
  end

endmodule

// File: rtl/clksw_div.sv
module clksw_div #(
  parameter int NUM_W = 31,
  parameter int DEN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic [NUM_W-1:0] quo
);

  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] q_q, q_d, n_q, n_d;
  logic [DEN_W-1:0] r_q, r_d, d_q, d_d;
  logic [CNT_W-1:0] c_q, c_d;
  logic             b_q, b_d;
  logic [DEN_W:0]   r_sh;

  always_comb begin
    q_d  = q_q;
    n_d  = n_q;
    r_d  = r_q;
    d_d  = d_q;
    c_d  = c_q;
    b_d  = b_q;
    r_sh = {r_q, q_q[NUM_W-1]};
    if (start) begin
      q_d = num;
      n_d = num;
      d_d = den;
      r_d = '0;
      c_d = CNT_W'(NUM_W);
      b_d = 1'b1;
    end else if (b_q) begin
      if (r_sh >= {1'b0, d_q}) begin
        r_d = DEN_W'(r_sh - {1'b0, d_q});
        q_d = {q_q[NUM_W-2:0], 1'b1};
      end else begin
        r_d = r_sh[DEN_W-1:0];
        q_d = {q_q[NUM_W-2:0], 1'b0};
      end
      c_d = c_q - CNT_W'(1);
      if (c_q == CNT_W'(1)) b_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= '0;
      n_q <= '0;
      r_q <= '0;
      d_q <= '0;
      c_q <= '0;
      b_q <= 1'b0;
    end else begin
      q_q <= q_d;
      n_q <= n_d;
      r_q <= r_d;
      d_q <= d_d;
      c_q <= c_d;
      b_q <= b_d;
    end
  end

  assign busy = b_q;
  assign quo  = q_q;

  // R2: the finished quotient and remainder rebuild the dividend
  a_r2_div_exact: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(b_q) |-> ((64'(q_q) * 64'(d_q) + 64'(r_q)) == 64'(n_q)));

  // R2: the remainder stays below the divisor
  a_r2_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(b_q) |-> (r_q < d_q));

endmodule

// File: rtl/clksw_refresh_seq.sv
module clksw_refresh_seq
  import clksw_pkg::*;
#(
  parameter int FREQ_W     = 24,
  parameter int DRI_W      = 12,
  parameter int REG_W      = 32,
  parameter int CFG_W      = 4,
  parameter int TREF_MS    = 64,
  parameter int FORMULA    = 0,
  parameter int STROBE_CYC = 4,
  parameter int DB2_A      = 17,
  parameter int DB2_B      = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [FREQ_W-1:0] req_freq_khz,
  input  logic              req_div2,
  input  logic [CFG_W-1:0]  req_clkcfg,
  input  logic [REG_W-1:0]  mem_cfg,
  input  logic [REG_W-1:0]  cur_refresh,
  input  logic              relock_ack,
  output logic              req_busy,
  output logic              ref_wr_en,
  output logic [REG_W-1:0]  ref_wr_data,
  output logic              clkcfg_wr_en,
  output logic [CFG_W-1:0]  clkcfg_wr_data,
  output logic              done
);

  localparam int TREF_W  = $clog2(TREF_MS + 1);
  localparam int NUM_W   = FREQ_W + TREF_W;
  localparam int ROW_W   = 15;
  localparam int DEN_W   = ROW_W + 5;
  localparam int STR_W   = $clog2(STROBE_CYC + 1);
  localparam int LEN_W   = STR_W + 1;
  localparam int DRI_MAX = (1 << DRI_W) - 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s = rsync_q[1];

  seq_state_t        st_q, st_d;
  logic [REG_W-1:0]  cur_q, cur_d, pre_q, pre_d, post_q, post_d;
  logic              div2_q, div2_d;
  logic [CFG_W-1:0]  cfg_q, cfg_d;
  logic [STR_W-1:0]  scnt_q, scnt_d;
  logic              accept, div_busy;
  logic [ROW_W-1:0]  rows;
  logic [DEN_W-1:0]  den;
  logic [NUM_W-1:0]  num, quo, dri_raw;
  logic [DRI_W-1:0]  dri_new;
  logic [REG_W-1:0]  db2_mask, pre_calc, post_calc;

  assign accept = req_valid && (st_q == ST_IDLE);
  assign num    = NUM_W'(req_freq_khz) * NUM_W'(TREF_MS);

  clksw_rowcount #(.CFG_W(REG_W), .ROW_W(ROW_W)) u_rows (
    .mem_cfg (mem_cfg),
    .rows    (rows)
  );

  generate
    if (FORMULA == 0) begin : g_rows_minus
      assign den     = DEN_W'(rows) - DEN_W'(31);
      assign dri_raw = quo >> 5;
    end else begin : g_rows_times
      assign den     = DEN_W'(rows) << 5;
      assign dri_raw = quo;
    end
  endgenerate

  clksw_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk   (clk),
    .rst_n (rst_s),
    .start (accept),
    .num   (num),
    .den   (den),
    .busy  (div_busy),
    .quo   (quo)
  );

  assign dri_new  = (dri_raw > NUM_W'(DRI_MAX)) ? DRI_W'(DRI_MAX) : dri_raw[DRI_W-1:0];
  assign db2_mask = (REG_W'(1) << DB2_A) | (REG_W'(1) << DB2_B);

  // preset applies only slowing changes; postset carries the final value
  always_comb begin
    post_calc = {cur_q[REG_W-1:DRI_W], dri_new};
    pre_calc  = cur_q;
    if (cur_q[DRI_W-1:0] > dri_new) pre_calc[DRI_W-1:0] = dri_new;
    if (div2_q) begin
      pre_calc  = pre_calc  | db2_mask;
      post_calc = post_calc | db2_mask;
    end else begin
      post_calc = post_calc & ~db2_mask;
    end
  end

  always_comb begin
    st_d   = st_q;
    cur_d  = cur_q;
    div2_d = div2_q;
    cfg_d  = cfg_q;
    pre_d  = pre_q;
    post_d = post_q;
    scnt_d = scnt_q;
    unique case (st_q)
      ST_IDLE: if (req_valid) begin
        st_d   = ST_CALC;
        cur_d  = cur_refresh;
        div2_d = req_div2;
        cfg_d  = req_clkcfg;
      end
      ST_CALC: if (!div_busy) begin
        st_d   = ST_PRE;
        pre_d  = pre_calc;
        post_d = post_calc;
      end
      ST_PRE: begin
        st_d   = ST_STRB;
        scnt_d = '0;
      end
      ST_STRB: begin
        if (scnt_q == STR_W'(STROBE_CYC - 1)) st_d = ST_WACK;
        else scnt_d = scnt_q + STR_W'(1);
      end
      ST_WACK: if (relock_ack) st_d = ST_POST;
      ST_POST: st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q   <= ST_IDLE;
      cur_q  <= '0;
      div2_q <= 1'b0;
      cfg_q  <= '0;
      pre_q  <= '0;
      post_q <= '0;
      scnt_q <= '0;
    end else begin
      st_q   <= st_d;
      cur_q  <= cur_d;
      div2_q <= div2_d;
      cfg_q  <= cfg_d;
      pre_q  <= pre_d;
      post_q <= post_d;
      scnt_q <= scnt_d;
    end
  end

  assign req_busy       = (st_q != ST_IDLE);
  assign ref_wr_en      = (st_q == ST_PRE) || (st_q == ST_POST);
  assign ref_wr_data    = (st_q == ST_POST) ? post_q : pre_q;
  assign clkcfg_wr_en   = (st_q == ST_STRB);
  assign clkcfg_wr_data = cfg_q | CFG_W'(1 << FCS_BIT);
  assign done           = (st_q == ST_DONE);

  // checker counter: length of the current strobe run
  logic [LEN_W-1:0] chk_len;
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)            chk_len <= '0;
    else if (clkcfg_wr_en) chk_len <= chk_len + LEN_W'(1);
    else                   chk_len <= '0;
  end

  // R7: strobe length
  a_r7_strobe_len: assert property (@(posedge clk) disable iff (!rst_s)
    $fell(clkcfg_wr_en) |-> (chk_len == LEN_W'(STROBE_CYC)));

  // R6: strobe begins right after the preset write
  a_r6_strobe_after_pre: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(clkcfg_wr_en) |-> $past(ref_wr_en));

  // R6: refresh write and strobe never overlap
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_s)
    !(ref_wr_en && clkcfg_wr_en));

  // R3: preset interval never exceeds the sampled one
  a_r3_preset_not_larger: assert property (@(posedge clk) disable iff (!rst_s)
    (st_q == ST_PRE) |-> (ref_wr_data[DRI_W-1:0] <= cur_q[DRI_W-1:0]));

  // R8: postset follows a sampled relock acknowledge
  a_r8_post_after_ack: assert property (@(posedge clk) disable iff (!rst_s)
    (st_q == ST_POST) |-> $past(relock_ack));

  // R9: done follows a refresh write
  a_r9_done_after_post: assert property (@(posedge clk) disable iff (!rst_s)
    done |-> $past(ref_wr_en));

  // R9: done lasts one cycle and ends busy
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_s)
    done |=> (!done && !req_busy));

endmodule

// File: tb/tb_clksw_refresh_seq.sv
`timescale 1ns/1ps
module tb_clksw_refresh_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [23:0] req_freq_khz;
  logic        req_div2;
  logic [3:0]  req_clkcfg;
  logic [31:0] mem_cfg;
  logic [31:0] cur_refresh;
  logic        relock_ack;
  logic        req_busy, ref_wr_en, clkcfg_wr_en, done;
  logic [31:0] ref_wr_data;
  logic [3:0]  clkcfg_wr_data;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  clksw_refresh_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_freq_khz(req_freq_khz),
    .req_div2(req_div2), .req_clkcfg(req_clkcfg), .mem_cfg(mem_cfg),
    .cur_refresh(cur_refresh), .relock_ack(relock_ack), .req_busy(req_busy),
    .ref_wr_en(ref_wr_en), .ref_wr_data(ref_wr_data), .clkcfg_wr_en(clkcfg_wr_en),
    .clkcfg_wr_data(clkcfg_wr_data), .done(done)
  );

  typedef struct packed {
    logic [23:0] freq;
    logic        div2;
    logic [3:0]  cfg;
    logic [31:0] mem;
    logic [31:0] cur;
    logic [31:0] exp_pre;
    logic [31:0] exp_post;
  } vec_t;

  // expected values worked out from R1..R5 by hand
  localparam vec_t VECS [5] = '{
    '{24'd99500,    1'b1, 4'h1, 32'h0000_0001, 32'h0000_0100, 32'h000A_0062, 32'h000A_0062},
    '{24'd208000,   1'b0, 4'h9, 32'h0021_0060, 32'h000A_0020, 32'h000A_0020, 32'h0000_0066},
    '{24'd16000000, 1'b0, 4'hD, 32'h0000_0060, 32'h0100_0800, 32'h0100_0800, 32'h0100_0FFF},
    '{24'd398100,   1'b1, 4'h5, 32'h0022_0042, 32'h0000_0061, 32'h000A_0061, 32'h000A_0061},
    '{24'd624000,   1'b0, 4'h0, 32'h0062_0000, 32'h0008_004D, 32'h0008_004C, 32'h0000_004C}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drives one request at a falling edge and watches the whole sequence
  task automatic do_seq(input vec_t v, input int ack_dly, input bit inject,
                        output logic [31:0] pre, output logic [31:0] post,
                        output logic [3:0] cfo, output int slen,
                        output bit ok_order, output bit ok_done, output bit ok_ack);
    int phase = 0;
    int waitc = 0;
    int post_c = -10;
    pre = '0; post = '0; cfo = '0; slen = 0;
    ok_order = 1'b1; ok_done = 1'b0; ok_ack = 1'b0;
    req_freq_khz = v.freq; req_div2 = v.div2; req_clkcfg = v.cfg;
    mem_cfg = v.mem; cur_refresh = v.cur; relock_ack = 1'b0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_busy == 1'b1, "R9 busy after accept", 32'(req_busy), 32'd1);
    for (int c = 0; c < 400; c++) begin
      if (inject && c == 3) begin
        req_valid = 1'b1; req_freq_khz = 24'd50000; req_div2 = ~v.div2;
        req_clkcfg = 4'h8; mem_cfg = 32'h0; cur_refresh = 32'hFFFF_FFFF;
      end else begin
        req_valid = 1'b0;
      end
      if (ref_wr_en) begin
        if (phase == 0) begin
          pre = ref_wr_data; phase = 1;
        end else if (phase == 3) begin
          post = ref_wr_data; phase = 4; post_c = c; ok_ack = relock_ack;
        end else begin
          ok_order = 1'b0;
        end
      end
      if (clkcfg_wr_en) begin
        if (phase == 1 || phase == 2) begin
          phase = 2; slen++; cfo = clkcfg_wr_data;
        end else begin
          ok_order = 1'b0;
        end
      end else if (phase == 2) begin
        phase = 3;
      end
      if (phase == 3) begin
        waitc++;
        if (waitc > ack_dly) relock_ack = 1'b1;
      end
      if (done) begin
        ok_done = (phase == 4) && (c == post_c + 1);
        break;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    relock_ack = 1'b0;
    if (phase != 4) ok_order = 1'b0;
    @(negedge clk);
    chk(req_busy == 1'b0, "R9 busy clears after done", 32'(req_busy), 32'd0);
  endtask

  task automatic run_vec(input int i, input int ack_dly, input bit inject);
    logic [31:0] pre, post;
    logic [3:0]  cfo;
    int          slen;
    bit          ok_order, ok_done, ok_ack;
    do_seq(VECS[i], ack_dly, inject, pre, post, cfo, slen, ok_order, ok_done, ok_ack);
    chk(pre == VECS[i].exp_pre, "R1 R2 R3 R5 preset value", pre, VECS[i].exp_pre);
    chk(post == VECS[i].exp_post, "R1 R2 R4 R5 postset value", post, VECS[i].exp_post);
    chk(cfo == (VECS[i].cfg | 4'h2), "R7 clock config word", 32'(cfo), 32'(VECS[i].cfg | 4'h2));
    chk(slen == 4, "R7 strobe length", 32'(slen), 32'd4);
    chk(ok_order, "R6 write order", 32'(ok_order), 32'd1);
    chk(ok_ack, "R8 postset after relock", 32'(ok_ack), 32'd1);
    chk(ok_done, "R9 done one cycle after postset", 32'(ok_done), 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_freq_khz = '0; req_div2 = 1'b0;
    req_clkcfg = '0; mem_cfg = '0; cur_refresh = '0; relock_ack = 1'b0;
    repeat (3) @(negedge clk);
    // R10: outputs quiet in reset
    chk({req_busy, done, ref_wr_en, clkcfg_wr_en} == 4'b0, "R10 quiet in reset",
        32'({req_busy, done, ref_wr_en, clkcfg_wr_en}), 32'd0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk({req_busy, done, ref_wr_en, clkcfg_wr_en} == 4'b0, "R10 quiet after reset",
        32'({req_busy, done, ref_wr_en, clkcfg_wr_en}), 32'd0);

    // table walk, stretching the relock wait on each entry
    for (int i = 0; i < 5; i++) begin
      run_vec(i, i * 3, 1'b0);
      repeat (2) @(negedge clk);
    end

    // R9: request made while busy is ignored
    run_vec(1, 2, 1'b1);
    begin
      bit stray = 1'b0;
      for (int c = 0; c < 60; c++) begin
        if (ref_wr_en || clkcfg_wr_en || req_busy) stray = 1'b1;
        @(negedge clk);
      end
      chk(!stray, "R9 refused request starts nothing", 32'(stray), 32'd0);
    end

    // R8: long relock wait, postset must hold off
    run_vec(4, 25, 1'b0);
    run_vec(0, 0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule